// File: doc/BRIEF.md
# SAR Conversion Sequencer

This block is the digital side of a successive-approximation converter. A start pulse launches a sequence over four or eight channels. Each conversion runs through a fixed timeline: an initial sample window, a transfer window, a final sample window whose length is programmable, one clock per result bit (MSB first), and one end-of-conversion cycle. During the bit cycles the block drives a trial code to an external comparator and reads back a single decision bit.

Each finished code goes into that channel's result register, and the channel's done flag is set. After the last channel of the selected length, a sequence-done flag is raised and the block goes idle. The mode inputs are captured at start, so changing them during a sequence has no effect on it. Both kinds of flag are cleared by write-one strobes, and a new start clears them as well. The comparator loop is a plain one-bit path with no handshake: the comparator must settle within one clock.

Top module: `sar_seq_ctrl`

## Requirements
- R1: After reset, `busy_o`, `chan_o`, `trial_o`, `ccf_o`, `scf_o` and every result field are zero.
- R2: A start pulse sampled at a clock edge makes `busy_o` high from the next cycle. Each conversion lasts 2 initial-sample + 2 transfer + final-sample + N bit cycles + 1 end cycle, where N is 10 or 8. Channels run in ascending order from 0, and `chan_o` shows the channel in progress.
- R3: The final sample window lasts 2 << `fs_sel_i` clocks (2, 4, 8 or 16). `fs_sel_i`, `res10_i` and `eight_ch_i` are captured at start, and later changes do not affect the running sequence.
- R4: In the first bit cycle `trial_o` is 0x200 (MSB only). In each bit cycle the bit under trial is kept when `cmp_i` is 1 and cleared when it is 0, and the next lower bit is set for the next trial.
- R5: With `res10_i`=0, only 8 bit cycles run (bits 9 down to 2). Bits [1:0] of `trial_o` and of the stored result are zero. With `res10_i`=1, all 10 bits are resolved.
- R6: At the edge that ends the end-of-conversion cycle, the final code is written to result field k (`result_o[10k+9:10k]`) and `ccf_o[k]` is set, for channel k.
- R7: With `eight_ch_i`=0, the sequence ends after channel 3; with 1, it ends after channel 7. At that edge `scf_o` is set and `busy_o` falls. Result fields of channels not converted keep their values.
- R8: A start pulse while busy aborts the sequence: all flags clear, no result is written, and the sequence restarts at channel 0. A start while idle also clears all flags.
- R9: `ccf_clr_i[k]`=1 clears `ccf_o[k]`, and `scf_clr_i`=1 clears `scf_o`. A flag set in the same cycle as its clear stays set.
- R10: `trial_o` is zero in the sample and transfer windows of every conversion, and holds the final code during the end cycle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Converter clock |
| rst_n | input | 1 | Active-low synchronous reset |
| start_i | input | 1 | Start (or restart) pulse |
| res10_i | input | 1 | 1: 10-bit resolution, 0: 8-bit |
| eight_ch_i | input | 1 | 1: eight-channel sequence, 0: four-channel |
| fs_sel_i | input | 2 | Final sample length select, 2 << value clocks |
| cmp_i | input | 1 | Comparator decision, 1 when input >= trial code |
| ccf_clr_i | input | 8 | Write-one-to-clear for the per-channel done flags |
| scf_clr_i | input | 1 | Write-one-to-clear for the sequence done flag |
| trial_o | output | 10 | Trial code to the DAC/comparator |
| busy_o | output | 1 | Sequence in progress |
| chan_o | output | 3 | Channel being converted |
| ccf_o | output | 8 | Per-channel conversion done flags |
| scf_o | output | 1 | Sequence done flag |
| result_o | output | 80 | Result registers, channel k at bits [10k+9:10k] |

## Verification
Flag and result updates land one register stage after the end cycle. The first done flag after a start is therefore visible 2+2+F+N+1 cycles after the capturing edge, and busy rises the cycle after start. The bench drives inputs on falling edges. It advances a behavioural model on rising edges, using its own comparator computed from the model's trial code, and compares every output on the next falling edge, so both sides see the same edge. Directed checks count falling edges from the start pulse to the first done flag, and compare result fields against codes computed from the analog stimulus values.

// File: rtl/sar_seq_pkg.sv
package sar_seq_pkg;
  typedef enum logic [2:0] {
    PH_IDLE,
    PH_INIT,
    PH_XFER,
    PH_FINAL,
    PH_RESOLVE,
    PH_EOC
  } phase_e;
endpackage

// File: rtl/sar_seq_timeline.sv
module sar_seq_timeline
  import sar_seq_pkg::*;
#(
  parameter int NCH      = 8,
  parameter int RBITS    = 10,
  parameter int LBITS    = 8,
  parameter int INIT_CYC = 2,
  parameter int XFER_CYC = 2,
  parameter int FSW      = 2,
  parameter int CNTW     = 5,
  parameter int CHW      = 3,
  parameter int BPW      = 4
) (
  input  logic            clk,
  input  logic            rst_n,
  input  logic            start_i,
  input  logic            res10_i,
  input  logic            eight_ch_i,
  input  logic [FSW-1:0]  fs_sel_i,
  output phase_e          phase_o,
  output logic [CHW-1:0]  chan_o,
  output logic [BPW-1:0]  bpos_o,
  output logic            more_o,
  output logic            sar_load_o,
  output logic            sar_clr_o,
  output logic            step_o,
  output logic            done_o,
  output logic            seq_end_o,
  output logic            res10_q_o
);
  phase_e           ph;
  logic [CNTW-1:0]  cnt;
  logic [CHW-1:0]   ch;
  logic             r10_q, e8_q;
  logic [FSW-1:0]   fs_q;
  logic [CNTW-1:0]  fs_len, nbits;
  logic [CHW-1:0]   last_ch;

  assign fs_len  = CNTW'(2) << fs_q;
  assign nbits   = r10_q ? CNTW'(RBITS) : CNTW'(LBITS);
  assign last_ch = e8_q ? CHW'(NCH - 1) : CHW'(NCH / 2 - 1);

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      ph <= PH_IDLE; cnt <= '0; ch <= '0;
      r10_q <= 1'b1; e8_q <= 1'b1; fs_q <= '0;
    end else if (start_i) begin
      ph <= PH_INIT; cnt <= '0; ch <= '0;
      r10_q <= res10_i; e8_q <= eight_ch_i; fs_q <= fs_sel_i;
    end else begin
      case (ph)
        PH_INIT:
          if (cnt == CNTW'(INIT_CYC - 1)) begin ph <= PH_XFER; cnt <= '0; end
          else cnt <= cnt + 1'b1;
        PH_XFER:
          if (cnt == CNTW'(XFER_CYC - 1)) begin ph <= PH_FINAL; cnt <= '0; end
          else cnt <= cnt + 1'b1;
        PH_FINAL:
          if (cnt == fs_len - 1'b1) begin ph <= PH_RESOLVE; cnt <= '0; end
          else cnt <= cnt + 1'b1;
        PH_RESOLVE:
          if (cnt == nbits - 1'b1) begin ph <= PH_EOC; cnt <= '0; end
          else cnt <= cnt + 1'b1;
        PH_EOC:
          if (ch == last_ch) ph <= PH_IDLE;
          else begin ch <= ch + 1'b1; ph <= PH_INIT; end
        default: ph <= PH_IDLE;
      endcase
    end
  end

  assign phase_o    = ph;
  assign chan_o     = ch;
  assign res10_q_o  = r10_q;
  assign bpos_o     = BPW'(RBITS - 1) - cnt[BPW-1:0];
  assign more_o     = (cnt != nbits - 1'b1);
  assign sar_load_o = !start_i && (ph == PH_FINAL) && (cnt == fs_len - 1'b1);
  assign step_o     = !start_i && (ph == PH_RESOLVE);
  assign done_o     = !start_i && (ph == PH_EOC);
  assign seq_end_o  = done_o && (ch == last_ch);
  assign sar_clr_o  = start_i || ((ph == PH_EOC) && (ch != last_ch));
endmodule

// File: rtl/sar_seq_bitreg.sv
module sar_seq_bitreg #(
  parameter int RBITS = 10,
  parameter int BPW   = 4
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             clr_i,
  input  logic             load_i,
  input  logic             step_i,
  input  logic [BPW-1:0]   bpos_i,
  input  logic             more_i,
  input  logic             cmp_i,
  output logic [RBITS-1:0] sar_o
);
  logic [RBITS-1:0] sar, sar_n;

  always_comb begin
    sar_n = sar;
    if (clr_i) sar_n = '0;
    else if (load_i) begin
      sar_n = '0;
      sar_n[RBITS-1] = 1'b1;
    end else if (step_i) begin
      sar_n[bpos_i] = cmp_i;
      if (more_i && bpos_i != '0) sar_n[bpos_i - 1'b1] = 1'b1;
    end
  end

  always_ff @(posedge clk) begin
    if (!rst_n) sar <= '0;
    else        sar <= sar_n;
  end

  assign sar_o = sar;
endmodule

// File: rtl/sar_seq_resbank.sv
module sar_seq_resbank #(
  parameter int NCH   = 8,
  parameter int RBITS = 10,
  parameter int CHW   = 3
) (
  input  logic                 clk,
  input  logic                 rst_n,
  input  logic                 start_i,
  input  logic                 wr_i,
  input  logic [CHW-1:0]       wch_i,
  input  logic [RBITS-1:0]     wdata_i,
  input  logic                 seq_end_i,
  input  logic [NCH-1:0]       ccf_clr_i,
  input  logic                 scf_clr_i,
  output logic [NCH*RBITS-1:0] result_o,
  output logic [NCH-1:0]       ccf_o,
  output logic                 scf_o
);
  for (genvar k = 0; k < NCH; k++) begin : g_chan
    logic hit;
    assign hit = wr_i && (wch_i == CHW'(k));

    always_ff @(posedge clk) begin
      if (!rst_n)   result_o[k*RBITS +: RBITS] <= '0;
      else if (hit) result_o[k*RBITS +: RBITS] <= wdata_i;
    end

    always_ff @(posedge clk) begin
      if (!rst_n)            ccf_o[k] <= 1'b0;
      else if (start_i)      ccf_o[k] <= 1'b0;
      else if (hit)          ccf_o[k] <= 1'b1;
      else if (ccf_clr_i[k]) ccf_o[k] <= 1'b0;
    end
  end

  always_ff @(posedge clk) begin
    if (!rst_n)         scf_o <= 1'b0;
    else if (start_i)   scf_o <= 1'b0;
    else if (seq_end_i) scf_o <= 1'b1;
    else if (scf_clr_i) scf_o <= 1'b0;
  end
endmodule

// File: rtl/sar_seq_ctrl.sv
module sar_seq_ctrl
  import sar_seq_pkg::*;
#(
  parameter int NCH      = 8,
  parameter int RBITS    = 10,
  parameter int LBITS    = 8,
  parameter int INIT_CYC = 2,
  parameter int XFER_CYC = 2,
  parameter int FSW      = 2
) (
  input  logic                 clk,
  input  logic                 rst_n,
  input  logic                 start_i,
  input  logic                 res10_i,
  input  logic                 eight_ch_i,
  input  logic [FSW-1:0]       fs_sel_i,
  input  logic                 cmp_i,
  input  logic [NCH-1:0]       ccf_clr_i,
  input  logic                 scf_clr_i,
  output logic [RBITS-1:0]     trial_o,
  output logic                 busy_o,
  output logic [$clog2(NCH)-1:0] chan_o,
  output logic [NCH-1:0]       ccf_o,
  output logic                 scf_o,
  output logic [NCH*RBITS-1:0] result_o
);
  localparam int CHW   = $clog2(NCH);
  localparam int BPW   = $clog2(RBITS);
  localparam int MAXFS = 2 << ((1 << FSW) - 1);
  localparam int CNTW  = $clog2((MAXFS > RBITS ? MAXFS : RBITS) + 1);

  phase_e           phase;
  logic [BPW-1:0]   bpos;
  logic             more, sar_load, sar_clr, step, done, seq_end, res10_q;

  sar_seq_timeline #(
    .NCH(NCH), .RBITS(RBITS), .LBITS(LBITS), .INIT_CYC(INIT_CYC),
    .XFER_CYC(XFER_CYC), .FSW(FSW), .CNTW(CNTW), .CHW(CHW), .BPW(BPW)
  ) u_tl (
    .clk(clk), .rst_n(rst_n), .start_i(start_i), .res10_i(res10_i),
    .eight_ch_i(eight_ch_i), .fs_sel_i(fs_sel_i), .phase_o(phase),
    .chan_o(chan_o), .bpos_o(bpos), .more_o(more), .sar_load_o(sar_load),
    .sar_clr_o(sar_clr), .step_o(step), .done_o(done), .seq_end_o(seq_end),
    .res10_q_o(res10_q)
  );

  sar_seq_bitreg #(.RBITS(RBITS), .BPW(BPW)) u_sar (
    .clk(clk), .rst_n(rst_n), .clr_i(sar_clr), .load_i(sar_load),
    .step_i(step), .bpos_i(bpos), .more_i(more), .cmp_i(cmp_i),
    .sar_o(trial_o)
  );

  sar_seq_resbank #(.NCH(NCH), .RBITS(RBITS), .CHW(CHW)) u_bank (
    .clk(clk), .rst_n(rst_n), .start_i(start_i), .wr_i(done),
    .wch_i(chan_o), .wdata_i(trial_o), .seq_end_i(seq_end),
    .ccf_clr_i(ccf_clr_i), .scf_clr_i(scf_clr_i), .result_o(result_o),
    .ccf_o(ccf_o), .scf_o(scf_o)
  );

  assign busy_o = (phase != PH_IDLE);
endmodule

// File: rtl/sar_seq_chk.sv
module sar_seq_chk
  import sar_seq_pkg::*;
#(
  parameter int NCH   = 8,
  parameter int RBITS = 10
) (
  input logic                   clk,
  input logic                   rst_n,
  input logic                   start_i,
  input logic                   busy_o,
  input logic [$clog2(NCH)-1:0] chan_o,
  input logic [RBITS-1:0]       trial_o,
  input logic [NCH-1:0]         ccf_o,
  input logic                   scf_o,
  input phase_e                 phase,
  input logic                   res10_q
);
  AST_MSB_FIRST_TRIAL: assert property (@(posedge clk) disable iff (!rst_n)
    (phase == PH_RESOLVE && $past(phase) == PH_FINAL) |-> trial_o == RBITS'(1 << (RBITS - 1))); // R4
  AST_LOWRES_LSBS_ZERO: assert property (@(posedge clk) disable iff (!rst_n)
    (!res10_q && phase == PH_RESOLVE) |-> trial_o[1:0] == 2'b00); // R5
  AST_ONE_CCF_PER_EDGE: assert property (@(posedge clk) disable iff (!rst_n)
    $countones(ccf_o & ~$past(ccf_o)) <= 1); // R6
  AST_SCF_ONLY_IDLE: assert property (@(posedge clk) disable iff (!rst_n)
    scf_o |-> !busy_o); // R7
  AST_START_RESTARTS: assert property (@(posedge clk) disable iff (!rst_n)
    start_i |=> (busy_o && chan_o == '0 && ccf_o == '0 && !scf_o)); // R8
  AST_SAMPLE_TRIAL_ZERO: assert property (@(posedge clk) disable iff (!rst_n)
    (phase == PH_INIT || phase == PH_XFER || phase == PH_FINAL) |-> trial_o == '0); // R10
endmodule

bind sar_seq_ctrl sar_seq_chk #(.NCH(NCH), .RBITS(RBITS)) chk_i (
  .clk(clk), .rst_n(rst_n), .start_i(start_i), .busy_o(busy_o),
  .chan_o(chan_o), .trial_o(trial_o), .ccf_o(ccf_o), .scf_o(scf_o),
  .phase(phase), .res10_q(res10_q)
);

// File: tb/sar_seq_ctrl_tb_top.sv
module sar_seq_ctrl_tb_top;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        start_i = 1'b0, res10_i = 1'b1, eight_ch_i = 1'b0;
  logic [1:0]  fs_sel_i = 2'd0;
  logic        cmp_i;
  logic [7:0]  ccf_clr_i = '0;
  logic        scf_clr_i = 1'b0;
  logic [9:0]  trial_o;
  logic        busy_o;
  logic [2:0]  chan_o;
  logic [7:0]  ccf_o;
  logic        scf_o;
  logic [79:0] result_o;

  int ain [8];
  int vectors = 0, errors = 0, cyc = 0;
  bit cmp_en = 1'b0;

  always #4 clk = ~clk;

  assign cmp_i = (ain[chan_o] >= int'(trial_o));

  sar_seq_ctrl dut_i (
    .clk(clk), .rst_n(rst_n), .start_i(start_i), .res10_i(res10_i),
    .eight_ch_i(eight_ch_i), .fs_sel_i(fs_sel_i), .cmp_i(cmp_i),
    .ccf_clr_i(ccf_clr_i), .scf_clr_i(scf_clr_i), .trial_o(trial_o),
    .busy_o(busy_o), .chan_o(chan_o), .ccf_o(ccf_o), .scf_o(scf_o),
    .result_o(result_o)
  );

  // behavioural reference: state 0 idle,1 initial,2 transfer,3 final,4 bits,5 end
  int m_state, m_cnt, m_ch, m_sar, m_res [8];
  int m_r10, m_e8, m_fs;
  logic [7:0] m_ccf;
  logic       m_scf;

  always @(posedge clk) begin
    if (!rst_n) begin
      m_state = 0; m_cnt = 0; m_ch = 0; m_sar = 0; m_ccf = '0; m_scf = 1'b0;
      m_r10 = 1; m_e8 = 1; m_fs = 0;
      for (int i = 0; i < 8; i++) m_res[i] = 0;
    end else begin
      logic [7:0] nccf;
      logic       nscf;
      nccf = m_ccf & ~ccf_clr_i;
      nscf = m_scf & ~scf_clr_i;
      if (start_i) begin
        m_state = 1; m_cnt = 0; m_ch = 0; m_sar = 0; nccf = '0; nscf = 1'b0;
        m_r10 = int'(res10_i); m_e8 = int'(eight_ch_i); m_fs = int'(fs_sel_i);
      end else begin
        case (m_state)
          1: if (m_cnt == 1) begin m_state = 2; m_cnt = 0; end else m_cnt++;
          2: if (m_cnt == 1) begin m_state = 3; m_cnt = 0; end else m_cnt++;
          3: if (m_cnt == (2 << m_fs) - 1) begin m_state = 4; m_cnt = 0; m_sar = 512; end
             else m_cnt++;
          4: begin
            int b, nb;
            b = 9 - m_cnt;
            nb = m_r10 ? 10 : 8;
            if (ain[m_ch] < m_sar) m_sar = m_sar & ~(1 << b);
            if (m_cnt == nb - 1) begin m_state = 5; m_cnt = 0; end
            else begin m_sar = m_sar | (1 << (b - 1)); m_cnt++; end
          end
          5: begin
            m_res[m_ch] = m_sar;
            nccf[m_ch] = 1'b1;
            if (m_ch == (m_e8 ? 7 : 3)) begin m_state = 0; nscf = 1'b1; end
            else begin m_ch++; m_state = 1; m_sar = 0; end
          end
          default: m_state = 0;
        endcase
      end
      m_ccf = nccf;
      m_scf = nscf;
    end
  end

  always @(negedge clk) begin
    if (cmp_en) begin
      vectors++;
      if (busy_o !== (m_state != 0)) begin
        errors++; $display("FAIL R2 busy act=%0b exp=%0b", busy_o, m_state != 0);
      end
      if (int'(chan_o) != m_ch) begin
        errors++; $display("FAIL R2 chan act=%0d exp=%0d", chan_o, m_ch);
      end
      if (int'(trial_o) != m_sar) begin
        errors++; $display("FAIL R4 R10 trial act=%0h exp=%0h", trial_o, m_sar);
      end
      if (ccf_o !== m_ccf) begin
        errors++; $display("FAIL R6 R9 ccf act=%0h exp=%0h", ccf_o, m_ccf);
      end
      if (scf_o !== m_scf) begin
        errors++; $display("FAIL R7 R9 scf act=%0b exp=%0b", scf_o, m_scf);
      end
      for (int i = 0; i < 8; i++)
        if (int'(result_o[i*10 +: 10]) != m_res[i]) begin
          errors++; $display("FAIL R6 result ch%0d act=%0h exp=%0h", i, result_o[i*10 +: 10], m_res[i]);
        end
    end
  end

  always @(posedge clk) begin
    cyc++;
    if (cyc > 150000) begin
      errors++;
      $display("FAIL R2 watchdog act=%0d exp<150000", cyc);
      $display("== %0d vectors applied, %0d miscompares ==", vectors, errors);
      $finish;
    end
  end

  task automatic chk(input bit ok, input string req, input int act, input int exp);
    vectors++;
    if (!ok) begin
      errors++;
      $display("FAIL %s act=%0d exp=%0d", req, act, exp);
    end
  endtask

  task automatic go(input bit r10, input bit e8, input int fs);
    @(negedge clk);
    res10_i = r10; eight_ch_i = e8; fs_sel_i = 2'(fs); start_i = 1'b1;
    @(negedge clk);
    start_i = 1'b0;
  endtask

  task automatic first_done(input int exp_k, input string req);
    int k;
    k = 1;
    while (!ccf_o[0] && k < 200) begin @(negedge clk); k++; end
    chk(k == exp_k, req, k, exp_k);
  endtask

  task automatic wait_idle();
    int n;
    n = 0;
    while (busy_o && n < 5000) begin @(negedge clk); n++; end
  endtask

  task automatic check_codes(input bit r10, input int first, input int last);
    for (int i = first; i <= last; i++) begin
      int e;
      e = r10 ? ain[i] : (ain[i] & 'h3FC);
      chk(int'(result_o[i*10 +: 10]) == e, r10 ? "R6 result" : "R5 result", int'(result_o[i*10 +: 10]), e);
    end
  endtask

  initial begin
    ain[0] = 300; ain[1] = 1023; ain[2] = 0; ain[3] = 513;
    ain[4] = 77; ain[5] = 700; ain[6] = 511; ain[7] = 2;
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    // R1 reset state
    chk(busy_o == 0 && ccf_o == 0 && scf_o == 0 && trial_o == 0 && chan_o == 0, "R1 reset", int'(busy_o), 0);
    chk(result_o == '0, "R1 results", int'(result_o[9:0]), 0);
    cmp_en = 1'b1;

    // 10-bit, four channels, final sample 2
    go(1'b1, 1'b0, 0);
    chk(busy_o == 1'b1, "R2 busy after start", int'(busy_o), 1);
    first_done(2 + 2 + 2 + 10 + 1 + 1, "R2 first done cycle");
    wait_idle();
    chk(scf_o == 1'b1, "R7 scf four-channel", int'(scf_o), 1);
    chk(ccf_o == 8'h0F, "R7 ccf four-channel", int'(ccf_o), 'h0F);
    check_codes(1'b1, 0, 3);
    chk(result_o[79:40] == '0, "R7 untouched channels", int'(result_o[49:40]), 0);

    // 8-bit, eight channels, final sample 16
    go(1'b0, 1'b1, 3);
    chk(ccf_o == 0 && scf_o == 0, "R8 start clears flags", int'(ccf_o), 0);
    first_done(2 + 2 + 16 + 8 + 1 + 1, "R3 R5 first done cycle");
    wait_idle();
    chk(ccf_o == 8'hFF && scf_o, "R7 eight-channel flags", int'(ccf_o), 'hFF);
    check_codes(1'b0, 0, 7);

    // R9 write-one clears
    @(negedge clk); ccf_clr_i = 8'h04;
    @(negedge clk); ccf_clr_i = '0;
    chk(ccf_o == 8'hFB, "R9 ccf clear", int'(ccf_o), 'hFB);
    scf_clr_i = 1'b1;
    @(negedge clk); scf_clr_i = 1'b0;
    chk(scf_o == 1'b0, "R9 scf clear", int'(scf_o), 0);

    // R9 set wins over a held clear, R3 mode changes ignored mid-run
    go(1'b1, 1'b1, 1);
    ccf_clr_i = 8'hFF;
    repeat (30) @(negedge clk);
    res10_i = 1'b0; eight_ch_i = 1'b0; fs_sel_i = 2'd2;
    ccf_clr_i = '0;
    // R8 abort mid-sequence
    repeat (20) @(negedge clk);
    start_i = 1'b1; res10_i = 1'b1; eight_ch_i = 1'b1; fs_sel_i = 2'd0;
    @(negedge clk);
    start_i = 1'b0;
    chk(busy_o && chan_o == 0 && ccf_o == 0 && !scf_o, "R8 abort restart", int'(chan_o), 0);
    res10_i = 1'b0;
    wait_idle();
    chk(ccf_o == 8'hFF, "R3 latched eight-channel", int'(ccf_o), 'hFF);
    check_codes(1'b1, 0, 7);

    // edge analog values, 10-bit
    ain[0] = 512; ain[1] = 511; ain[2] = 1; ain[3] = 1022;
    go(1'b1, 1'b0, 2);
    first_done(2 + 2 + 8 + 10 + 1 + 1, "R3 final sample 8");
    wait_idle();
    check_codes(1'b1, 0, 3);
    chk(int'(result_o[79:70]) == ain[7], "R7 channel 7 kept", int'(result_o[79:70]), ain[7]);

    repeat (4) @(negedge clk);
    $display("== %0d vectors applied, %0d miscompares ==", vectors, errors);
    $finish;
  end
endmodule